// File: doc/BRIEF.md
# Double-Buffered Fractional Enable Control Register

This block is the control register that selects which fractional-resolution features one PWM submodule uses. There are three enables: fractional period length, fractional edge placement for output A, and fractional edge placement for output B. Each enable has two copies. Software writes and reads the staging copy. The live copy drives the PWM generator. The staging copy reaches the live copy only at a safe moment, so the generator never runs with a half-applied configuration.

Writes arrive on a plain write strobe with a data word, and the register image is always visible on a read bus. Software arms a transfer by raising the load-armed input. The next load-cycle strobe from the PWM counter then copies all staged enables into the live copy on one edge. An immediate-load mode input bypasses the wait for the strobe. While the transfer is armed, software cannot alter the staged enables.

The same register holds a power-up bit for the fractional delay line that all submodules share. This bit is not double-buffered. The block combines it with the power-up bits of the peer submodules into one power-down signal for the shared delay line.

Top module: `frac_ctl_reg`

## Requirements
- R1: After a synchronous reset, the read bus is all zero, all three live enables are 0, and the power-down output is 1.
- R2: A write while load-armed is 0 stores the staged enables from data bits 1 (period), 2 (edge A) and 4 (edge B). The read bus shows them at the same positions from the next cycle.
- R3: Bits 0, 3, 5 to 7 and 9 to 15 of the read bus always read 0, whatever was written.
- R4: A write while load-armed is 1 leaves the staged enables (bits 1, 2 and 4) unchanged.
- R5: The read bus reports the staged enables even when they differ from the live enables.
- R6: When load-armed and the load-cycle strobe are both 1 at a clock edge, all three live enables take the staged values together on that edge.
- R7: Outside immediate-load mode, the live enables hold their value on any edge where load-armed and the load-cycle strobe are not both 1.
- R8: While immediate-load mode is 1, the live enables equal the staged value on the clock edge after an accepted write.
- R9: Bit 8 is the power-up bit. It is written by every write, including one made while load-armed is 1, takes effect on the next edge, and reads back its current value.
- R10: The power-down output is 1 exactly when the local power-up bit and every peer power-up input are 0.
- R11: A live enable of 1 selects its fractional feature, and 0 bypasses it. The three live enable outputs map directly to period, edge A and edge B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register image |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register image: staged enables and power-up bit |
| load_armed | input | 1 | Software load-ok flag that arms the transfer |
| load_cycle | input | 1 | Start-of-load-cycle strobe from the PWM counter |
| imm_load | input | 1 | Immediate-load mode |
| peer_pwr_up | input | N_PEERS | Power-up bits of the other submodules |
| act_period_en | output | 1 | Live fractional-period enable |
| act_edge_a_en | output | 1 | Live fractional edge-A enable |
| act_edge_b_en | output | 1 | Live fractional edge-B enable |
| frac_pwr_down | output | 1 | Power-down request for the shared delay line |

## Verification
The bench builds the block with N_PEERS set to 3. This makes the power-down merge small enough to sweep every combination of the local bit and the three peer bits. The write sweep covers all 512 values of the low nine data bits, with the load-cycle strobe pulsing and load-armed low, so every reserved bit and every enable position is exercised. The transfer is checked for all eight enable patterns: first staged, then locked against a complementary write, then applied by the strobe. The same eight patterns are then checked again in immediate-load mode.

// File: rtl/frac_ctl_pkg.sv
package frac_ctl_pkg;

    localparam int REG_W      = 16;
    localparam int POS_PERIOD = 1;
    localparam int POS_EDGE_A = 2;
    localparam int POS_EDGE_B = 4;
    localparam int POS_PWR    = 8;

    typedef struct packed {
        logic edge_b;
        logic edge_a;
        logic period;
    } frac_en_t;

    localparam frac_en_t EN_OFF = '{edge_b: 1'b0, edge_a: 1'b0, period: 1'b0};

    function automatic frac_en_t unpack_en(input logic [REG_W-1:0] word);
        frac_en_t e;
        e.period = word[POS_PERIOD];
        e.edge_a = word[POS_EDGE_A];
        e.edge_b = word[POS_EDGE_B];
        return e;
    endfunction

    function automatic logic [REG_W-1:0] pack_image(input frac_en_t e, input logic pwr);
        logic [REG_W-1:0] w;
        w             = '0;
        w[POS_PERIOD] = e.period;
        w[POS_EDGE_A] = e.edge_a;
        w[POS_EDGE_B] = e.edge_b;
        w[POS_PWR]    = pwr;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] used_mask();
        logic [REG_W-1:0] m;
        m             = '0;
        m[POS_PERIOD] = 1'b1;
        m[POS_EDGE_A] = 1'b1;
        m[POS_EDGE_B] = 1'b1;
        m[POS_PWR]    = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/frac_stage_reg.sv
module frac_stage_reg
    import frac_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             load_armed,
    output frac_en_t         stage_en,
    output logic             pwr_up
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_en <= EN_OFF;
            pwr_up   <= 1'b0;
        end else if (wr_en) begin
            pwr_up <= wr_data[POS_PWR];
            if (!load_armed) begin
                stage_en <= unpack_en(wr_data);
            end
        end
    end

    // R4: staged enables cannot move while a transfer is armed
    assert_locked_R4: assert property (@(posedge clk) disable iff (rst)
        load_armed |=> $stable(stage_en));

    // R9: power-up bit follows every write regardless of arming
    assert_pwr_write_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> pwr_up == $past(wr_data[POS_PWR]));

endmodule

// File: rtl/frac_live_reg.sv
module frac_live_reg
    import frac_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  frac_en_t stage_en,
    input  logic     load_armed,
    input  logic     load_cycle,
    input  logic     imm_load,
    output frac_en_t live_en
);

    logic do_xfer;

    always_comb begin
        do_xfer = imm_load | (load_armed & load_cycle);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_en <= EN_OFF;
        end else if (do_xfer) begin
            live_en <= stage_en;
        end
    end

    // R6: an armed load-cycle edge applies the whole staged word
    assert_xfer_R6: assert property (@(posedge clk) disable iff (rst)
        (load_armed && load_cycle) |=> live_en == $past(stage_en));

    // R7: no armed strobe and no immediate mode means the live word holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!imm_load && !(load_armed && load_cycle)) |=> $stable(live_en));

    // R8: immediate mode copies the staged word on the following edge
    assert_imm_R8: assert property (@(posedge clk) disable iff (rst)
        imm_load |=> live_en == $past(stage_en));

endmodule

// File: rtl/frac_pwr_merge.sv
module frac_pwr_merge #(
    parameter int N_PEERS = 3
) (
    input  logic               local_up,
    input  logic [N_PEERS-1:0] peer_up,
    output logic               pwr_down
);

    localparam int N_ALL = N_PEERS + 1;

    logic [N_ALL-1:0] all_up;

    generate
        if (N_PEERS > 0) begin : g_peers
            always_comb all_up = {peer_up, local_up};
        end else begin : g_solo
            always_comb all_up = local_up;
        end
    endgenerate

    always_comb begin
        pwr_down = (all_up == '0);
    end

endmodule

// File: rtl/frac_ctl_reg.sv
module frac_ctl_reg
    import frac_ctl_pkg::*;
#(
    parameter int N_PEERS = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic               load_armed,
    input  logic               load_cycle,
    input  logic               imm_load,
    input  logic [N_PEERS-1:0] peer_pwr_up,
    output logic               act_period_en,
    output logic               act_edge_a_en,
    output logic               act_edge_b_en,
    output logic               frac_pwr_down
);

    localparam logic [REG_W-1:0] RSV_MASK = ~used_mask();

    frac_en_t stage_en;
    frac_en_t live_en;
    logic     pwr_up;

    frac_stage_reg u_stage (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .load_armed (load_armed),
        .stage_en   (stage_en),
        .pwr_up     (pwr_up)
    );

    frac_live_reg u_live (
        .clk        (clk),
        .rst        (rst),
        .stage_en   (stage_en),
        .load_armed (load_armed),
        .load_cycle (load_cycle),
        .imm_load   (imm_load),
        .live_en    (live_en)
    );

    frac_pwr_merge #(.N_PEERS(N_PEERS)) u_pwr (
        .local_up (pwr_up),
        .peer_up  (peer_pwr_up),
        .pwr_down (frac_pwr_down)
    );

    // R5: the read image is built from the staged copy, never the live one
    always_comb begin
        rd_data = pack_image(stage_en, pwr_up);
    end

    // R11: live enables map one-to-one onto the feature selects
    always_comb begin
        act_period_en = live_en.period;
        act_edge_a_en = live_en.edge_a;
        act_edge_b_en = live_en.edge_b;
    end

    // R3: reserved positions of the read image stay zero
    always_comb begin
        if (!rst) begin
            assert_rsv_zero_R3: assert ((rd_data & RSV_MASK) == '0);
        end
    end

    // R10: a locally powered delay line is never reported as powered down
    assert_pwr_keep_R10: assert property (@(posedge clk) disable iff (rst)
        rd_data[POS_PWR] |-> !frac_pwr_down);

endmodule

// File: tb/test_frac_ctl_reg.sv
`timescale 1ns/1ps
module test_frac_ctl_reg;

    localparam int NP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        load_armed = 1'b0;
    logic        load_cycle = 1'b0;
    logic        imm_load = 1'b0;
    logic [NP-1:0] peer_pwr_up = '0;
    logic        act_period_en, act_edge_a_en, act_edge_b_en, frac_pwr_down;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    frac_ctl_reg #(.N_PEERS(NP)) i_frac_ctl_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .load_armed(load_armed), .load_cycle(load_cycle), .imm_load(imm_load),
        .peer_pwr_up(peer_pwr_up), .act_period_en(act_period_en),
        .act_edge_a_en(act_edge_a_en), .act_edge_b_en(act_edge_b_en),
        .frac_pwr_down(frac_pwr_down)
    );

    function automatic logic [15:0] img(input logic [2:0] en, input logic pu);
        logic [15:0] w = '0;
        w[1] = en[0]; w[2] = en[1]; w[4] = en[2]; w[8] = pu;
        return w;
    endfunction

    function automatic logic [2:0] live();
        return {act_edge_b_en, act_edge_a_en, act_period_en};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_img;
        logic [2:0]  exp_live;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
        check(live() == 3'b0, "R1 live", live(), 0);
        check(frac_pwr_down == 1'b1, "R1 pwr_down", frac_pwr_down, 1);

        // R2 R3 R7: sweep low nine bits, strobe pulsing without arming
        for (int v = 0; v < 512; v++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_data = v[15:0] | 16'hFE00; load_cycle = 1'b1;
            @(negedge clk);
            wr_en = 1'b0; load_cycle = 1'b0;
            exp_img = img({v[4], v[2], v[1]}, v[8]);
            check(rd_data == exp_img, "R2 R3 readback", rd_data, exp_img);
            check(live() == 3'b0, "R7 live held", live(), 0);
        end

        // R4 R5 R6 R9 R11: stage, lock, apply
        exp_live = 3'b0;
        for (int p = 0; p < 8; p++) begin
            wr(img(p[2:0], 1'b0));
            @(negedge clk);
            load_armed = 1'b1;
            wr(img(~p[2:0], 1'b1));
            exp_img = img(p[2:0], 1'b1);
            check(rd_data == exp_img, "R4 locked write", rd_data, exp_img);
            check(rd_data[8] == 1'b1, "R9 pwr bit written while armed", rd_data[8], 1);
            check(live() == exp_live, "R5 live differs from read", live(), exp_live);
            @(negedge clk);
            load_cycle = 1'b1;
            @(negedge clk);
            load_cycle = 1'b0;
            load_armed = 1'b0;
            exp_live = p[2:0];
            check(live() == exp_live, "R6 R11 transfer", live(), exp_live);
            wr(16'h0000);
            check(rd_data == 16'h0, "R9 pwr bit cleared", rd_data, 0);
            check(live() == exp_live, "R5 live kept after restage", live(), exp_live);
        end

        // R8: immediate-load mode
        @(negedge clk);
        imm_load = 1'b1;
        for (int p = 7; p >= 0; p--) begin
            @(negedge clk);
            wr_en = 1'b1; wr_data = img(p[2:0], 1'b0);
            @(posedge clk);
            @(posedge clk);
            wr_en = 1'b0;
            @(negedge clk);
            check(live() == p[2:0], "R8 immediate", live(), p);
        end
        @(negedge clk);
        imm_load = 1'b0;

        // R10: power merge exhaustive
        for (int c = 0; c < 16; c++) begin
            wr(img(3'b0, c[0]));
            peer_pwr_up = c[3:1];
            #1;
            check(frac_pwr_down == (c == 0), "R10 pwr_down", frac_pwr_down, (c == 0));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule